// File: doc/BRIEF.md
# Pin Bank Controller with Atomic Set, Clear and Toggle

This block owns a bank of 32 general-purpose pins behind a small memory-mapped bus with a word address, write data, a write strobe and read data. It keeps an output latch that drives every pin's output value and a per-pin direction register that drives every pin's output enable. It also returns the pin levels through a two-stage synchronizer.

Software can change individual latch bits without a read-modify-write sequence. It does this through three write-only alias words that set, clear or invert the latch bits selected by ones in the write data. Bits written as zero keep their value. The latch can also be loaded whole through its own word.

Reads are combinational: the read data reflects the current address in the same cycle. Writes take effect at the clock edge that samples the strobe.

Top module: `gpio_sct_port`

## Requirements
- R1: After reset the output latch and the direction register are all zero, so `pin_out` and `pin_oe` are zero and both words read back zero.
- R2: A write to byte address 0x00 loads the whole output latch. The new value appears on `pin_out` after that clock edge and reads back at 0x00.
- R3: A write to 0x04 sets to 1 each latch bit whose write-data bit is 1 and leaves the other latch bits unchanged.
- R4: A write to 0x08 clears to 0 each latch bit whose write-data bit is 1 and leaves the other latch bits unchanged.
- R5: A write to 0x0C inverts each latch bit whose write-data bit is 1 and leaves the other latch bits unchanged.
- R6: Reads of 0x04, 0x08 and 0x0C return zero.
- R7: A write to 0x14 loads the direction register. A bit of 1 makes that pin an output, so `pin_oe` equals the register after the edge, and the register reads back at 0x14.
- R8: A read of 0x10 returns `pin_in` as it was sampled two clock edges earlier, through two flops. A write to 0x10 changes neither the latch nor the direction register.
- R9: An address other than the six listed words reads zero, and a write to it has no effect. This includes any address with bit 1 or bit 0 set, or any address above 0x1F.
- R10: `pin_out` changes only on a write to 0x00, 0x04, 0x08 or 0x0C, and `pin_oe` changes only on a write to 0x14.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 32 | Byte address of the access |
| bus_wdata | input | 32 | Write data |
| bus_we | input | 1 | Write strobe, sampled at the rising edge |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| pin_in | input | 32 | Pin levels from the pads, asynchronous |
| pin_out | output | 32 | Output value per pin (latch) |
| pin_oe | output | 32 | Output enable per pin (direction) |

## Verification
A write is due on `pin_out`, `pin_oe` and the readback one edge after the strobe is sampled. The bench therefore drives the strobe at a falling edge and compares at the next falling edge, with the rising edge between them. Read data is combinational, so each read sets the address and samples shortly after, away from any edge. A pin-input change is due at 0x10 only after the second rising edge. The bench confirms the old value after one edge and the new value after two. Hold and no-effect cases are checked at the ports in the same slot, before the next write.

// File: rtl/gpio_sct_port.sv
module gpio_sct_port #(
  parameter int NPINS = 32,
  parameter int AW    = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [AW-1:0]    bus_addr,
  input  logic [NPINS-1:0] bus_wdata,
  input  logic             bus_we,
  output logic [NPINS-1:0] bus_rdata,
  input  logic [NPINS-1:0] pin_in,
  output logic [NPINS-1:0] pin_out,
  output logic [NPINS-1:0] pin_oe
);
  localparam logic [2:0] W_LATCH = 3'd0;
  localparam logic [2:0] W_SET   = 3'd1;
  localparam logic [2:0] W_CLR   = 3'd2;
  localparam logic [2:0] W_TGL   = 3'd3;
  localparam logic [2:0] W_IN    = 3'd4;
  localparam logic [2:0] W_DIR   = 3'd5;

  logic [NPINS-1:0] latch_q, dir_q, sync1_q, sync2_q;
  logic             in_map, wr_hit;
  logic [2:0]       widx;

  assign in_map = (bus_addr[AW-1:5] == '0) && (bus_addr[1:0] == 2'b00);
  assign widx   = bus_addr[4:2];
  assign wr_hit = bus_we && in_map;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      latch_q <= '0;
    end else if (wr_hit) begin
      case (widx)
        W_LATCH: latch_q <= bus_wdata;
        W_SET:   latch_q <= latch_q | bus_wdata;
        W_CLR:   latch_q <= latch_q & ~bus_wdata;
        W_TGL:   latch_q <= latch_q ^ bus_wdata;
        default: latch_q <= latch_q;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) dir_q <= '0;
    else if (wr_hit && widx == W_DIR) dir_q <= bus_wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync1_q <= '0;
      sync2_q <= '0;
    end else begin
      sync1_q <= pin_in;
      sync2_q <= sync1_q;
    end
  end

  always_comb begin
    bus_rdata = '0;
    if (in_map) begin
      case (widx)
        W_LATCH: bus_rdata = latch_q;
        W_IN:    bus_rdata = sync2_q;
        W_DIR:   bus_rdata = dir_q;
        default: bus_rdata = '0;
      endcase
    end
  end

  assign pin_out = latch_q;
  assign pin_oe  = dir_q;
endmodule

// File: rtl/gpio_sct_port_chk.sv
module gpio_sct_port_chk #(
  parameter int NPINS = 32,
  parameter int AW    = 32
) (
  input logic             clk,
  input logic             rst_n,
  input logic [AW-1:0]    bus_addr,
  input logic [NPINS-1:0] bus_wdata,
  input logic             bus_we,
  input logic [NPINS-1:0] bus_rdata,
  input logic [NPINS-1:0] pin_in,
  input logic [NPINS-1:0] pin_out,
  input logic [NPINS-1:0] pin_oe
);
  logic [1:0] warm_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) warm_q <= 2'd0;
    else if (warm_q != 2'd2) warm_q <= warm_q + 2'd1;
  end

  logic a0, a4, a8, ac, a10, a14, mapped;
  assign a0  = bus_addr == AW'(32'h00);
  assign a4  = bus_addr == AW'(32'h04);
  assign a8  = bus_addr == AW'(32'h08);
  assign ac  = bus_addr == AW'(32'h0C);
  assign a10 = bus_addr == AW'(32'h10);
  assign a14 = bus_addr == AW'(32'h14);
  assign mapped = a0 | a4 | a8 | ac | a10 | a14 | (bus_addr == AW'(32'h18)) | (bus_addr == AW'(32'h1C));

  a_r2_direct_load: assert property (@(posedge clk) disable iff (!rst_n)
    bus_we && a0 |=> pin_out == $past(bus_wdata));
  a_r3_set_bits: assert property (@(posedge clk) disable iff (!rst_n)
    bus_we && a4 |=> pin_out == ($past(pin_out) | $past(bus_wdata)));
  a_r4_clear_bits: assert property (@(posedge clk) disable iff (!rst_n)
    bus_we && a8 |=> pin_out == ($past(pin_out) & ~$past(bus_wdata)));
  a_r5_toggle_bits: assert property (@(posedge clk) disable iff (!rst_n)
    bus_we && ac |=> pin_out == ($past(pin_out) ^ $past(bus_wdata)));
  a_r6_alias_read_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (a4 || a8 || ac) |-> bus_rdata == '0);
  a_r7_dir_load: assert property (@(posedge clk) disable iff (!rst_n)
    bus_we && a14 |=> pin_oe == $past(bus_wdata));
  a_r8_sync_delay: assert property (@(posedge clk) disable iff (!rst_n)
    (warm_q == 2'd2) && a10 |-> bus_rdata == $past(pin_in, 2));
  a_r9_unmapped_zero: assert property (@(posedge clk) disable iff (!rst_n)
    !mapped |-> bus_rdata == '0);
  a_r10_out_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_we && (a0 || a4 || a8 || ac)) |=> $stable(pin_out));
  a_r10_oe_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_we && a14) |=> $stable(pin_oe));
endmodule

bind gpio_sct_port gpio_sct_port_chk #(.NPINS(NPINS), .AW(AW)) chk_i (
  .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
  .bus_we(bus_we), .bus_rdata(bus_rdata), .pin_in(pin_in),
  .pin_out(pin_out), .pin_oe(pin_oe)
);

// File: tb/gpio_sct_port_tb_top.sv
`timescale 1ns/1ps
module gpio_sct_port_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] bus_addr = '0, bus_wdata = '0, bus_rdata, pin_in = '0, pin_out, pin_oe;
  logic        bus_we = 1'b0;
  int total = 0, bad = 0;
  bit done = 1'b0;
  logic [31:0] exp_out = '0, exp_dir = '0;

  always #2.5 clk = ~clk;

  gpio_sct_port dut_i (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_we(bus_we), .bus_rdata(bus_rdata), .pin_in(pin_in),
    .pin_out(pin_out), .pin_oe(pin_oe)
  );

  task automatic check(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic bus_wr(input logic [31:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_we = 1'b1;
    @(negedge clk);
    bus_we = 1'b0; bus_wdata = '0;
  endtask

  task automatic bus_rd(input logic [31:0] a, output logic [31:0] d);
    bus_addr = a;
    #1;
    d = bus_rdata;
  endtask

  task automatic check_pins(input string req);
    logic [31:0] r;
    check(req, "pin_out", pin_out, exp_out);
    check(req, "pin_oe", pin_oe, exp_dir);
    bus_rd(32'h00, r); check(req, "latch readback", r, exp_out);
    bus_rd(32'h14, r); check(req, "dir readback", r, exp_dir);
  endtask

  task automatic t_reset();
    check_pins("R1");
  endtask

  task automatic t_direct();
    bus_wr(32'h00, 32'hA5A5_0F0F); exp_out = 32'hA5A5_0F0F; check_pins("R2");
    bus_wr(32'h00, 32'h1234_8001); exp_out = 32'h1234_8001; check_pins("R2");
  endtask

  task automatic t_set();
    logic [31:0] r;
    bus_wr(32'h04, 32'h0000_F0F0); exp_out = exp_out | 32'h0000_F0F0; check_pins("R3");
    bus_wr(32'h04, 32'h8000_0001); exp_out = exp_out | 32'h8000_0001; check_pins("R3");
    bus_wr(32'h04, 32'h0); check_pins("R3");
    bus_rd(32'h04, r); check("R6", "set alias read", r, 32'h0);
  endtask

  task automatic t_clear();
    logic [31:0] r;
    bus_wr(32'h08, 32'hFF00_00F0); exp_out = exp_out & ~32'hFF00_00F0; check_pins("R4");
    bus_wr(32'h08, 32'h0); check_pins("R4");
    bus_rd(32'h08, r); check("R6", "clear alias read", r, 32'h0);
  endtask

  task automatic t_toggle();
    logic [31:0] r;
    bus_wr(32'h0C, 32'hFFFF_0000); exp_out = exp_out ^ 32'hFFFF_0000; check_pins("R5");
    bus_wr(32'h0C, 32'h0F0F_0F0F); exp_out = exp_out ^ 32'h0F0F_0F0F; check_pins("R5");
    bus_wr(32'h0C, 32'h0F0F_0F0F); exp_out = exp_out ^ 32'h0F0F_0F0F; check_pins("R5");
    bus_rd(32'h0C, r); check("R6", "toggle alias read", r, 32'h0);
  endtask

  task automatic t_dir();
    bus_wr(32'h14, 32'hC3C3_00FF); exp_dir = 32'hC3C3_00FF; check_pins("R7");
    bus_wr(32'h14, 32'h0000_FFFF); exp_dir = 32'h0000_FFFF; check_pins("R7");
    bus_wr(32'h04, 32'h0001_0000); exp_out = exp_out | 32'h0001_0000;
    check_pins("R10");
  endtask

  task automatic t_input();
    logic [31:0] r;
    @(negedge clk); pin_in = 32'hDEAD_BEEF;
    bus_rd(32'h10, r); check("R8", "input before edge", r, 32'h0);
    @(negedge clk); bus_rd(32'h10, r); check("R8", "input after one edge", r, 32'h0);
    @(negedge clk); bus_rd(32'h10, r); check("R8", "input after two edges", r, 32'hDEAD_BEEF);
    pin_in = 32'h0F00_0001;
    @(negedge clk); bus_rd(32'h10, r); check("R8", "second change after one edge", r, 32'hDEAD_BEEF);
    @(negedge clk); bus_rd(32'h10, r); check("R8", "second change after two edges", r, 32'h0F00_0001);
    bus_wr(32'h10, 32'hFFFF_FFFF); check_pins("R8");
    bus_rd(32'h10, r); check("R8", "input after write", r, 32'h0F00_0001);
  endtask

  task automatic t_unmapped();
    logic [31:0] r;
    bus_wr(32'h18, 32'hFFFF_FFFF); check_pins("R9");
    bus_wr(32'h1C, 32'hFFFF_FFFF); check_pins("R9");
    bus_wr(32'h100, 32'h5555_5555); check_pins("R9");
    bus_wr(32'h02, 32'hFFFF_FFFF); check_pins("R9");
    bus_wr(32'h15, 32'h0); check_pins("R9");
    bus_rd(32'h18, r); check("R9", "read 0x18", r, 32'h0);
    bus_rd(32'h01, r); check("R9", "read misaligned", r, 32'h0);
    bus_rd(32'h8000_0000, r); check("R9", "read high", r, 32'h0);
    bus_rd(32'h110, r); check("R9", "read alias of input", r, 32'h0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_direct();
    t_set();
    t_clear();
    t_toggle();
    t_dir();
    t_input();
    t_unmapped();
    repeat (2) @(negedge clk);
    check_pins("R10");
    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule